// File: doc/BRIEF.md
# Host Word Data Port

This block streams the contents of a sector buffer to a processor, one 16-bit word per read. A transfer is prepared by loading a starting byte address and a byte count, and is then opened by an external transfer-active flag. Each accepted read request returns the byte at the current address as the upper half of the word and the byte that follows it as the lower half. The address then moves forward by two and the count goes down by two. The read that exhausts the count still returns its word. In the same cycle that word is presented, the block pulses an end indication, may pulse a clear of the end-of-transfer interrupt flag, and may raise a one-cycle level-5 interrupt request.

Two processors share the port, and a 3-bit destination mode chooses which of them the port serves. A request from the processor that is not selected, or any request made while no transfer is open, is answered with a zero word and leaves every register untouched. The buffer is filled through its own byte write port. Its depth is a power-of-two parameter, so buffer indices wrap modulo that depth and the 16-bit data address wraps modulo 65536.

The controller is a six-state machine. WAIT is the idle state, where requests are accepted. Every other state is a one-cycle response state that returns to WAIT: WORD delivers an ordinary word, NULL delivers a rejected zero, END delivers the final word with the end pulse only, END_DTE adds the flag clear, and END_IRQ adds the flag clear and the interrupt. From WAIT the machine moves on a request as follows. With no open transfer or the wrong processor it goes to NULL. Otherwise, if the count is above 2 it goes to WORD. If the count is at or below 2, it goes to END when interface-control bit 6 is clear, to END_DTE when that bit is set and interrupt-mask bit 5 is clear, and to END_IRQ when both bits are set.

Top module: `hwdp_top`

## Requirements
- R1: After reset the data address and byte count read 0, and rd_valid, end_pulse, dte_flag_clr and irq5_req are all 0.
- R2: A request made while xfer_active is 0 is answered one cycle later with rd_valid=1 and rd_data=0. The address and count do not change, and no end, clear or interrupt pulse occurs.
- R3: A request is served only when rd_sub=0 with dest_mode=3'b010 (main processor), or rd_sub=1 with dest_mode=3'b011 (sub processor). Any other combination, including any other mode value, is answered with a zero word and changes nothing.
- R4: For an accepted request, rd_valid is 1 for exactly the next cycle. In that cycle rd_data[15:8] is the buffer byte at the data address and rd_data[7:0] is the byte at the address plus one.
- R5: An accepted request adds 2 to the data address (modulo 65536). When the count before the request is above 2, it also subtracts 2 from the count. Both new values are visible in the response cycle.
- R6: When an accepted request finds the count at 2 or less (including 1 or 0), the count becomes 0 and end_pulse is 1 during the response cycle, while that same cycle still carries the word.
- R7: On that final response, dte_flag_clr is 1 exactly when if_ctrl bit 6 is 1.
- R8: On that final response, irq5_req is 1 exactly when if_ctrl bit 6 and irq_mask bit 5 are both 1, and it lasts a single cycle.
- R9: ld_addr_en and ld_count_en load ld_value into the address or the count, visible the next cycle. A load in the same cycle as an accepted request overrides that request's update of the same register, while the request still reads at the old address.
- R10: A request still asserted during the response cycle is not accepted. One request yields one word and one step.
- R11: The buffer index is the data address modulo BUF_BYTES, and the second byte of a word wraps to index 0 after the last buffer byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_wr_en | input | 1 | Write one byte into the sector buffer |
| buf_wr_addr | input | BW | Buffer byte index for the write |
| buf_wr_data | input | 8 | Byte to write |
| ld_addr_en | input | 1 | Load the data address from ld_value |
| ld_count_en | input | 1 | Load the byte count from ld_value |
| ld_value | input | REG_W | Value for either load |
| xfer_active | input | 1 | A transfer is open |
| dest_mode | input | 3 | Destination selector; 2 = main, 3 = sub |
| if_ctrl | input | 8 | Interface control byte; bit 6 enables the end flag clear |
| irq_mask | input | 8 | Interrupt mask; bit 5 enables the level-5 request |
| rd_req | input | 1 | Read request, sampled in the idle state |
| rd_sub | input | 1 | Requester: 0 main, 1 sub |
| rd_valid | output | 1 | Response cycle for a request |
| rd_data | output | 16 | Returned word |
| data_addr | output | REG_W | Current data address |
| byte_count | output | REG_W | Remaining byte count |
| end_pulse | output | 1 | Transfer finished: set host end, clear host ready, set status bit 3, drop active |
| dte_flag_clr | output | 1 | Clear the end-of-transfer interrupt status flag |
| irq5_req | output | 1 | One-cycle level-5 interrupt request |

## Verification
The final word and the end-of-transfer actions come out in the same response cycle, so a fault could drop the word, delay the end pulse by a cycle, or let the interrupt outlive that cycle. The bench forces this coincidence by running a table of reads down to a count of 2, then by loading counts of 2, 1 and 0 under different if_ctrl and irq_mask settings. In each of those response cycles it samples rd_data, byte_count, end_pulse, dte_flag_clr and irq5_req together and compares them with a model of the address and count kept in the bench. It checks one cycle later that the interrupt has dropped.

// File: rtl/hwdp_pkg.sv
package hwdp_pkg;

    typedef enum logic [2:0] {
        ST_WAIT    = 3'd0,
        ST_WORD    = 3'd1,
        ST_NULL    = 3'd2,
        ST_END     = 3'd3,
        ST_END_DTE = 3'd4,
        ST_END_IRQ = 3'd5
    } hwdp_state_e;

    localparam logic [2:0] DEST_MAIN     = 3'd2;
    localparam logic [2:0] DEST_SUB      = 3'd3;
    localparam int         CTRL_DTE_BIT  = 6;
    localparam int         MASK_IRQ_BIT  = 5;
    localparam int         BYTES_PER_RD  = 2;

endpackage

// File: rtl/hwdp_sector_buf.sv
module hwdp_sector_buf #(
    parameter int BUF_BYTES = 2048,
    parameter int BW        = 11
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    input  logic [BW-1:0] rd_addr,
    output logic [15:0]   rd_word
);
    import hwdp_pkg::*;

    logic [7:0] mem [BUF_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // One registered read lane per byte of the word; lane 0 is the upper byte.
    for (genvar l = 0; l < BYTES_PER_RD; l++) begin : g_lane
        logic [BW-1:0] lane_addr;
        logic [7:0]    lane_q;
        assign lane_addr = rd_addr + BW'(l);
        always_ff @(posedge clk) begin
            if (rd_en) begin
                lane_q <= mem[lane_addr];
            end
        end
        assign rd_word[15-8*l -: 8] = lane_q;
    end

endmodule

// File: rtl/hwdp_ptr_regs.sv
module hwdp_ptr_regs #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_addr_en,
    input  logic             ld_count_en,
    input  logic [REG_W-1:0] ld_value,
    input  logic             step,
    output logic [REG_W-1:0] addr_q,
    output logic [REG_W-1:0] count_q,
    output logic             last
);
    import hwdp_pkg::*;

    localparam logic [REG_W-1:0] STEP_BYTES = REG_W'(BYTES_PER_RD);

    // The step that would bring the count to zero or below ends the transfer.
    assign last = (count_q <= STEP_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (ld_addr_en) begin
            addr_q <= ld_value;
        end else if (step) begin
            addr_q <= addr_q + STEP_BYTES;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (ld_count_en) begin
            count_q <= ld_value;
        end else if (step) begin
            count_q <= last ? '0 : (count_q - STEP_BYTES);
        end
    end

endmodule

// File: rtl/hwdp_fsm.sv
module hwdp_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_req,
    input  logic       rd_sub,
    input  logic       xfer_active,
    input  logic [2:0] dest_mode,
    input  logic       dte_enable,
    input  logic       irq_enable,
    input  logic       last,
    output logic       step,
    output logic       rd_valid,
    output logic       data_en,
    output logic       end_pulse,
    output logic       dte_clr,
    output logic       irq_req
);
    import hwdp_pkg::*;

    hwdp_state_e state_q, state_d;
    logic        sel_ok;

    always_comb begin
        sel_ok = xfer_active && (rd_sub ? (dest_mode == DEST_SUB)
                                        : (dest_mode == DEST_MAIN));
        step   = (state_q == ST_WAIT) && rd_req && sel_ok;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (rd_req) begin
                    if (!sel_ok)          state_d = ST_NULL;
                    else if (!last)       state_d = ST_WORD;
                    else if (!dte_enable) state_d = ST_END;
                    else if (!irq_enable) state_d = ST_END_DTE;
                    else                  state_d = ST_END_IRQ;
                end
            end
            ST_WORD:    state_d = ST_WAIT;
            ST_NULL:    state_d = ST_WAIT;
            ST_END:     state_d = ST_WAIT;
            ST_END_DTE: state_d = ST_WAIT;
            ST_END_IRQ: state_d = ST_WAIT;
            default:    state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rd_valid  = 1'b0;
        data_en   = 1'b0;
        end_pulse = 1'b0;
        dte_clr   = 1'b0;
        irq_req   = 1'b0;
        unique case (state_q)
            ST_WAIT: ;
            ST_WORD: begin
                rd_valid = 1'b1;
                data_en  = 1'b1;
            end
            ST_NULL: begin
                rd_valid = 1'b1;
            end
            ST_END: begin
                rd_valid  = 1'b1;
                data_en   = 1'b1;
                end_pulse = 1'b1;
            end
            ST_END_DTE: begin
                rd_valid  = 1'b1;
                data_en   = 1'b1;
                end_pulse = 1'b1;
                dte_clr   = 1'b1;
            end
            ST_END_IRQ: begin
                rd_valid  = 1'b1;
                data_en   = 1'b1;
                end_pulse = 1'b1;
                dte_clr   = 1'b1;
                irq_req   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/hwdp_top.sv
module hwdp_top #(
    parameter int BUF_BYTES = 2048,
    parameter int REG_W     = 16,
    parameter int BW        = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_wr_en,
    input  logic [BW-1:0]    buf_wr_addr,
    input  logic [7:0]       buf_wr_data,
    input  logic             ld_addr_en,
    input  logic             ld_count_en,
    input  logic [REG_W-1:0] ld_value,
    input  logic             xfer_active,
    input  logic [2:0]       dest_mode,
    input  logic [7:0]       if_ctrl,
    input  logic [7:0]       irq_mask,
    input  logic             rd_req,
    input  logic             rd_sub,
    output logic             rd_valid,
    output logic [15:0]      rd_data,
    output logic [REG_W-1:0] data_addr,
    output logic [REG_W-1:0] byte_count,
    output logic             end_pulse,
    output logic             dte_flag_clr,
    output logic             irq5_req
);
    import hwdp_pkg::*;

    logic        step;
    logic        last;
    logic        data_en;
    logic [15:0] buf_word;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{if_ctrl[7], if_ctrl[5:0], irq_mask[7:6], irq_mask[4:0]};

    if (REG_W > BW) begin : g_addr_hi
        logic unused_addr_hi;
        assign unused_addr_hi = ^data_addr[REG_W-1:BW];
    end

    hwdp_ptr_regs #(
        .REG_W (REG_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_addr_en  (ld_addr_en),
        .ld_count_en (ld_count_en),
        .ld_value    (ld_value),
        .step        (step),
        .addr_q      (data_addr),
        .count_q     (byte_count),
        .last        (last)
    );

    hwdp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (rd_req),
        .rd_sub      (rd_sub),
        .xfer_active (xfer_active),
        .dest_mode   (dest_mode),
        .dte_enable  (if_ctrl[CTRL_DTE_BIT]),
        .irq_enable  (irq_mask[MASK_IRQ_BIT]),
        .last        (last),
        .step        (step),
        .rd_valid    (rd_valid),
        .data_en     (data_en),
        .end_pulse   (end_pulse),
        .dte_clr     (dte_flag_clr),
        .irq_req     (irq5_req)
    );

    hwdp_sector_buf #(
        .BUF_BYTES (BUF_BYTES),
        .BW        (BW)
    ) u_buf (
        .clk     (clk),
        .wr_en   (buf_wr_en),
        .wr_addr (buf_wr_addr),
        .wr_data (buf_wr_data),
        .rd_en   (step),
        .rd_addr (data_addr[BW-1:0]),
        .rd_word (buf_word)
    );

    assign rd_data = data_en ? buf_word : 16'h0000;

endmodule

// File: rtl/hwdp_checker.sv
module hwdp_checker #(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_active,
    input logic             ld_addr_en,
    input logic             rd_req,
    input logic             rd_valid,
    input logic [15:0]      rd_data,
    input logic [REG_W-1:0] data_addr,
    input logic [REG_W-1:0] byte_count,
    input logic             end_pulse,
    input logic             dte_flag_clr,
    input logic             irq5_req
);

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq5_req |=> !irq5_req);

    assert_irq_with_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq5_req |-> (end_pulse && dte_flag_clr));

    assert_dte_with_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dte_flag_clr |-> end_pulse);

    assert_end_count_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |-> (byte_count == '0));

    assert_end_carries_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |-> rd_valid);

    assert_valid_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_inactive_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !$past(xfer_active) && !$past(ld_addr_en))
        |-> (rd_data == 16'h0000 && data_addr == $past(data_addr) && !end_pulse));

endmodule

bind hwdp_top hwdp_checker #(
    .REG_W (REG_W)
) u_hwdp_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_active  (xfer_active),
    .ld_addr_en   (ld_addr_en),
    .rd_req       (rd_req),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .data_addr    (data_addr),
    .byte_count   (byte_count),
    .end_pulse    (end_pulse),
    .dte_flag_clr (dte_flag_clr),
    .irq5_req     (irq5_req)
);

// File: tb/hwdp_top_test.sv
`timescale 1ns/1ps
module hwdp_top_test;

    localparam int BUF_BYTES = 2048;
    localparam int BW        = 11;
    localparam int NVEC      = 9;

    // Row fields: {rd_sub, dest_mode[2:0], xfer_active}
    localparam logic [4:0] VEC [NVEC] = '{
        5'b0_010_1, 5'b1_010_1, 5'b1_011_1, 5'b0_011_1, 5'b0_010_0,
        5'b0_101_1, 5'b0_010_1, 5'b1_011_1, 5'b0_010_1
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          buf_wr_en = 1'b0;
    logic [BW-1:0] buf_wr_addr = '0;
    logic [7:0]    buf_wr_data = '0;
    logic          ld_addr_en = 1'b0;
    logic          ld_count_en = 1'b0;
    logic [15:0]   ld_value = '0;
    logic          xfer_active = 1'b0;
    logic [2:0]    dest_mode = 3'd2;
    logic [7:0]    if_ctrl = 8'h40;
    logic [7:0]    irq_mask = 8'h20;
    logic          rd_req = 1'b0;
    logic          rd_sub = 1'b0;
    logic          rd_valid;
    logic [15:0]   rd_data;
    logic [15:0]   data_addr;
    logic [15:0]   byte_count;
    logic          end_pulse;
    logic          dte_flag_clr;
    logic          irq5_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    hwdp_top #(.BUF_BYTES(BUF_BYTES), .REG_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr),
        .buf_wr_data(buf_wr_data), .ld_addr_en(ld_addr_en), .ld_count_en(ld_count_en),
        .ld_value(ld_value), .xfer_active(xfer_active), .dest_mode(dest_mode),
        .if_ctrl(if_ctrl), .irq_mask(irq_mask), .rd_req(rd_req), .rd_sub(rd_sub),
        .rd_valid(rd_valid), .rd_data(rd_data), .data_addr(data_addr),
        .byte_count(byte_count), .end_pulse(end_pulse), .dte_flag_clr(dte_flag_clr),
        .irq5_req(irq5_req)
    );

    function automatic logic [7:0] pat(input int idx);
        return 8'((idx % BUF_BYTES) * 37 + 11);
    endfunction

    function automatic logic [15:0] word_at(input int a);
        return {pat(a), pat(a + 1)};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic a, input logic c, input logic [15:0] v);
        @(negedge clk);
        ld_addr_en = a; ld_count_en = c; ld_value = v;
        @(negedge clk);
        ld_addr_en = 1'b0; ld_count_en = 1'b0;
    endtask

    logic        s_v, s_e, s_dt, s_ir;
    logic [15:0] s_d;

    task automatic do_read(input logic sub);
        @(negedge clk);
        rd_req = 1'b1; rd_sub = sub;
        @(negedge clk);
        s_v = rd_valid; s_d = rd_data; s_e = end_pulse; s_dt = dte_flag_clr; s_ir = irq5_req;
        rd_req = 1'b0;
    endtask

    task automatic final_case(input string req, input logic [15:0] cnt,
                              input logic [7:0] ctl, input logic [7:0] msk,
                              input logic exp_dte, input logic exp_irq);
        if_ctrl = ctl; irq_mask = msk;
        load(1'b1, 1'b1, 16'h0040);
        load(1'b0, 1'b1, cnt);
        do_read(1'b0);
        chk(req, "final word", s_d, word_at(16'h0040));
        chk(req, "end pulse", s_e, 1);
        chk(req, "count zero", byte_count, 0);
        chk("R7", "dte clear", s_dt, exp_dte);
        chk("R8", "irq", s_ir, exp_irq);
        @(negedge clk);
        chk("R8", "irq dropped", irq5_req, 0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int m_addr;
        int m_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "addr", data_addr, 0);
        chk("R1", "count", byte_count, 0);
        chk("R1", "valid", rd_valid, 0);
        chk("R1", "pulses", {end_pulse, dte_flag_clr, irq5_req}, 0);

        for (int i = 0; i < BUF_BYTES; i++) begin
            buf_wr_en = 1'b1; buf_wr_addr = BW'(i); buf_wr_data = pat(i);
            @(negedge clk);
        end
        buf_wr_en = 1'b0;

        // R9 loads
        load(1'b1, 1'b0, 16'h0010);
        chk("R9", "addr load", data_addr, 16'h0010);
        load(1'b0, 1'b1, 16'h000A);
        chk("R9", "count load", byte_count, 16'h000A);

        // Table walk: selection, data order, stepping and the final word
        m_addr = 16'h0010; m_cnt = 10;
        for (int i = 0; i < NVEC; i++) begin
            logic sub, act, acc, lst;
            logic [2:0] mode;
            logic [15:0] exp_d;
            string tag;
            sub = VEC[i][4]; mode = VEC[i][3:1]; act = VEC[i][0];
            acc = act && (sub ? (mode == 3'd3) : (mode == 3'd2));
            lst = acc && (m_cnt <= 2);
            exp_d = acc ? word_at(m_addr) : 16'h0000;
            if (acc) begin
                m_addr = (m_addr + 2) & 16'hFFFF;
                m_cnt = (m_cnt - 2 <= 0) ? 0 : m_cnt - 2;
            end
            tag = acc ? "R4" : (act ? "R3" : "R2");
            dest_mode = mode; xfer_active = act;
            do_read(sub);
            chk(tag, "valid", s_v, 1);
            chk(tag, "data", s_d, exp_d);
            chk("R5", "addr", data_addr, m_addr);
            chk("R5", "count", byte_count, m_cnt);
            chk("R6", "end", s_e, lst);
            chk("R7", "dte", s_dt, lst);
            chk("R8", "irq", s_ir, lst);
        end
        xfer_active = 1'b1; dest_mode = 3'd2;

        // R9 load wins over a same-cycle step; the read still uses the old address
        load(1'b1, 1'b1, 16'h0100);
        load(1'b0, 1'b1, 16'h0006);
        @(negedge clk);
        rd_req = 1'b1; rd_sub = 1'b0; ld_addr_en = 1'b1; ld_value = 16'h0200;
        @(negedge clk);
        chk("R9", "data old addr", rd_data, word_at(16'h0100));
        chk("R9", "addr loaded", data_addr, 16'h0200);
        chk("R9", "count stepped", byte_count, 16'h0004);
        rd_req = 1'b0; ld_addr_en = 1'b0;

        // R10 request held through the response cycle
        load(1'b1, 1'b1, 16'h0020);
        load(1'b0, 1'b1, 16'h0008);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        chk("R10", "first valid", rd_valid, 1);
        @(negedge clk);
        chk("R10", "no second valid", rd_valid, 0);
        chk("R10", "single step addr", data_addr, 16'h0022);
        chk("R10", "single step count", byte_count, 16'h0006);
        rd_req = 1'b0;
        @(negedge clk);

        // R11 buffer and address wrap
        load(1'b1, 1'b1, 16'hFFFF);
        load(1'b0, 1'b1, 16'h0008);
        do_read(1'b1);
        chk("R3", "sub rejected in main mode", s_d, 0);
        do_read(1'b0);
        chk("R11", "wrap word", s_d, {pat(BUF_BYTES - 1), pat(0)});
        chk("R11", "addr wrap", data_addr, 16'h0001);

        // R6, R7, R8 end variants
        final_case("R6", 16'h0002, 8'h02, 8'h20, 1'b0, 1'b0);
        final_case("R6", 16'h0001, 8'h40, 8'h00, 1'b1, 1'b0);
        final_case("R6", 16'h0000, 8'h40, 8'h20, 1'b1, 1'b1);

        // R2 inactive read after a finished transfer leaves registers alone
        xfer_active = 1'b0;
        load(1'b1, 1'b1, 16'h0300);
        do_read(1'b0);
        chk("R2", "zero word", s_d, 0);
        chk("R2", "addr kept", data_addr, 16'h0300);
        chk("R2", "count kept", byte_count, 16'h0300);
        chk("R2", "no end", s_e, 0);

        done = 1'b1;
        finish_run();
    end

endmodule